// File: doc/BRIEF.md
# Dual-Issue Register Rename Table

This block renames a pair of instructions each cycle: an older slot X and a younger slot Y. Each slot names two source registers out of eight logical registers and may name one destination. For every source the block returns the 5-bit physical tag that currently holds its value. For every destination it hands out a physical tag taken fresh from a pool of 32, together with the tag that the logical register held before, so that the older tag can be returned to the pool once nothing can read it any more.

Inside a pair, the younger slot sees the older slot's work. If Y reads a register that X writes, Y gets X's new tag. If X reads a register that Y writes, X still gets the old tag. If both write the same logical register, each gets its own tag and Y's tag becomes the final mapping. Two tags per cycle can be handed back to the pool. If the pool cannot cover the pair's demand, the whole pair is held off with a stall output and nothing is committed.

Top module: `rename_pair`

## Requirements
- R1: After a synchronous reset, logical register i maps to physical tag i and the free pool holds exactly tags 8 to 31, so the first two allocations are tags 8 and 9.
- R2: Each source output gives the committed mapping of the logical register it names. An X source is never affected by Y's destination in the same pair.
- R3: A Y source that names the logical destination of an allocating X in the same, non-stalled pair receives X's new tag.
- R4: A slot allocates when its valid and destination-enable inputs are both 1. X takes the lowest-numbered free tag. Y takes the next lowest, or the lowest if X does not allocate. A slot that does not allocate outputs tag 0 as its destination.
- R5: Each slot's old-tag output gives the mapping its destination held before the slot. For Y, when X allocates the same logical register in the pair, that is X's new tag.
- R6: At the clock edge the mapping of each allocating destination takes the new tag. When both slots write the same logical register, Y's tag is the one that remains.
- R7: A slot with valid 0 or destination-enable 0 allocates nothing, changes no mapping and causes no forwarding to Y.
- R8: Up to two release inputs per cycle return tags to the free pool, and those tags can be allocated from the next cycle on.
- R9: When the pool holds fewer free tags than the pair needs, stall is 1. Both destination outputs read 0, the sources show the committed mapping, and no mapping or allocation changes that cycle. Releases still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| x_valid | input | 1 | Older slot holds an instruction |
| x_src0 | input | 3 | Older slot first source register |
| x_src1 | input | 3 | Older slot second source register |
| x_dst_en | input | 1 | Older slot writes a register |
| x_dst | input | 3 | Older slot destination register |
| y_valid | input | 1 | Younger slot holds an instruction |
| y_src0 | input | 3 | Younger slot first source register |
| y_src1 | input | 3 | Younger slot second source register |
| y_dst_en | input | 1 | Younger slot writes a register |
| y_dst | input | 3 | Younger slot destination register |
| rel0_en | input | 1 | First release strobe |
| rel0_tag | input | 5 | First tag returned to the pool |
| rel1_en | input | 1 | Second release strobe |
| rel1_tag | input | 5 | Second tag returned to the pool |
| x_psrc0 | output | 5 | Physical tag for x_src0 |
| x_psrc1 | output | 5 | Physical tag for x_src1 |
| x_pdst | output | 5 | New tag for the older destination |
| x_pold | output | 5 | Previous tag of the older destination |
| y_psrc0 | output | 5 | Physical tag for y_src0 |
| y_psrc1 | output | 5 | Physical tag for y_src1 |
| y_pdst | output | 5 | New tag for the younger destination |
| y_pold | output | 5 | Previous tag of the younger destination |
| stall | output | 1 | Pool too small, pair not renamed |

## Verification
Some properties are checked on every cycle. A newly allocated tag is never one that any logical register currently maps to, and the two new tags of a pair always differ. A stalled cycle leaves the whole mapping untouched. The table comes back as identity after reset, and a release never names a tag that is already free. Only the bench scenarios can show the exact allocation order, the forwarding of X's tag into Y, the outcome when both slots write the same register, exhaustion of the pool, and a released tag being used again.

// File: rtl/rename_pkg.sv
package rename_pkg;

    localparam int unsigned LOG_REGS  = 8;
    localparam int unsigned PHYS_REGS = 32;
    localparam int unsigned LOG_W     = $clog2(LOG_REGS);
    localparam int unsigned TAG_W     = $clog2(PHYS_REGS);
    localparam int unsigned CNT_W     = $clog2(PHYS_REGS + 1);

    typedef logic [LOG_W-1:0] lreg_t;
    typedef logic [TAG_W-1:0] ptag_t;
    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [PHYS_REGS-1:0] free_vec_t;
    typedef logic [LOG_REGS-1:0][TAG_W-1:0] map_vec_t;

    typedef struct packed {
        logic  valid;
        lreg_t src0;
        lreg_t src1;
        logic  dst_en;
        lreg_t dst;
    } slot_req_t;

    typedef struct packed {
        ptag_t psrc0;
        ptag_t psrc1;
        ptag_t pdst;
        ptag_t pold;
    } slot_rsp_t;

    // lowest set index of a pool vector (0 when empty)
    function automatic ptag_t lowest_set(free_vec_t v);
        ptag_t r = '0;
        for (int i = PHYS_REGS - 1; i >= 0; i--) begin
            if (v[i]) r = ptag_t'(i);
        end
        return r;
    endfunction

    function automatic free_vec_t drop_lowest(free_vec_t v);
        return v & (v - free_vec_t'(1));
    endfunction

    function automatic cnt_t count_ones(free_vec_t v);
        cnt_t c = '0;
        for (int i = 0; i < PHYS_REGS; i++) begin
            c = c + cnt_t'(v[i]);
        end
        return c;
    endfunction

    function automatic map_vec_t identity_map();
        map_vec_t m;
        for (int i = 0; i < LOG_REGS; i++) begin
            m[i] = ptag_t'(i);
        end
        return m;
    endfunction

    function automatic free_vec_t reset_pool();
        free_vec_t v;
        for (int i = 0; i < PHYS_REGS; i++) begin
            v[i] = (i >= LOG_REGS);
        end
        return v;
    endfunction

    function automatic logic tag_in_map(map_vec_t m, ptag_t t);
        logic hit = 1'b0;
        for (int i = 0; i < LOG_REGS; i++) begin
            if (m[i] == t) hit = 1'b1;
        end
        return hit;
    endfunction

endpackage

// File: rtl/rn_free_list.sv
module rn_free_list
    import rename_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  need_x,
    input  logic  need_y,
    input  logic  rel0_en,
    input  ptag_t rel0_tag,
    input  logic  rel1_en,
    input  ptag_t rel1_tag,
    output ptag_t x_tag,
    output ptag_t y_tag,
    output logic  stall
);

    free_vec_t pool_q;
    free_vec_t pool_d;
    cnt_t      avail;
    cnt_t      demand;
    ptag_t     first_tag;
    ptag_t     second_tag;
    logic      take_x;
    logic      take_y;

    always_comb begin
        avail      = count_ones(pool_q);
        demand     = cnt_t'(need_x) + cnt_t'(need_y);
        stall      = (avail < demand);
        first_tag  = lowest_set(pool_q);
        second_tag = lowest_set(drop_lowest(pool_q));
        x_tag      = first_tag;
        y_tag      = need_x ? second_tag : first_tag;
        take_x     = need_x && !stall;
        take_y     = need_y && !stall;
    end

    always_comb begin
        pool_d = pool_q;
        if (take_x)  pool_d[x_tag]    = 1'b0;
        if (take_y)  pool_d[y_tag]    = 1'b0;
        if (rel0_en) pool_d[rel0_tag] = 1'b1;
        if (rel1_en) pool_d[rel1_tag] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) pool_q <= reset_pool();
        else     pool_q <= pool_d;
    end

    // R8: a returned tag must be one that is in use
    a_r8_release_in_use0: assert property (@(posedge clk) disable iff (rst)
        rel0_en |-> !pool_q[rel0_tag]);
    a_r8_release_in_use1: assert property (@(posedge clk) disable iff (rst)
        rel1_en |-> !pool_q[rel1_tag]);
    // R1: pool is back to its initial contents after reset
    a_r1_pool_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (count_ones(pool_q) == cnt_t'(PHYS_REGS - LOG_REGS)));

endmodule

// File: rtl/rn_map_table.sv
module rn_map_table
    import rename_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_x_en,
    input  lreg_t    wr_x_reg,
    input  ptag_t    wr_x_tag,
    input  logic     wr_y_en,
    input  lreg_t    wr_y_reg,
    input  ptag_t    wr_y_tag,
    output map_vec_t map_q
);

    // younger port written last so it wins on a shared register
    always_ff @(posedge clk) begin
        if (rst) begin
            map_q <= identity_map();
        end else begin
            if (wr_x_en) map_q[wr_x_reg] <= wr_x_tag;
            if (wr_y_en) map_q[wr_y_reg] <= wr_y_tag;
        end
    end

    // R1: identity mapping after reset
    a_r1_identity_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (map_q == identity_map()));
    // R6: when both ports hit one register the younger tag remains
    a_r6_younger_wins: assert property (@(posedge clk) disable iff (rst)
        (wr_x_en && wr_y_en && wr_x_reg == wr_y_reg) |=> (map_q[$past(wr_y_reg)] == $past(wr_y_tag)));

endmodule

// File: rtl/rn_pair_resolve.sv
module rn_pair_resolve
    import rename_pkg::*;
(
    input  slot_req_t x_req,
    input  slot_req_t y_req,
    input  map_vec_t  map_q,
    input  ptag_t     x_tag,
    input  ptag_t     y_tag,
    input  logic      stall,
    output logic      need_x,
    output logic      need_y,
    output logic      commit_x,
    output logic      commit_y,
    output slot_rsp_t x_rsp,
    output slot_rsp_t y_rsp
);

    logic fwd_src0;
    logic fwd_src1;
    logic fwd_old;

    always_comb begin
        need_x   = x_req.valid && x_req.dst_en;
        need_y   = y_req.valid && y_req.dst_en;
        commit_x = need_x && !stall;
        commit_y = need_y && !stall;

        // older slot sees only the committed table
        x_rsp.psrc0 = map_q[x_req.src0];
        x_rsp.psrc1 = map_q[x_req.src1];
        x_rsp.pold  = map_q[x_req.dst];
        x_rsp.pdst  = commit_x ? x_tag : '0;

        // younger slot picks up the older slot's new tag
        fwd_src0 = commit_x && (y_req.src0 == x_req.dst);
        fwd_src1 = commit_x && (y_req.src1 == x_req.dst);
        fwd_old  = commit_x && (y_req.dst  == x_req.dst);

        y_rsp.psrc0 = fwd_src0 ? x_tag : map_q[y_req.src0];
        y_rsp.psrc1 = fwd_src1 ? x_tag : map_q[y_req.src1];
        y_rsp.pold  = fwd_old  ? x_tag : map_q[y_req.dst];
        y_rsp.pdst  = commit_y ? y_tag : '0;
    end

endmodule

// File: rtl/rename_pair.sv
module rename_pair
    import rename_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             x_valid,
    input  logic [LOG_W-1:0] x_src0,
    input  logic [LOG_W-1:0] x_src1,
    input  logic             x_dst_en,
    input  logic [LOG_W-1:0] x_dst,
    input  logic             y_valid,
    input  logic [LOG_W-1:0] y_src0,
    input  logic [LOG_W-1:0] y_src1,
    input  logic             y_dst_en,
    input  logic [LOG_W-1:0] y_dst,
    input  logic             rel0_en,
    input  logic [TAG_W-1:0] rel0_tag,
    input  logic             rel1_en,
    input  logic [TAG_W-1:0] rel1_tag,
    output logic [TAG_W-1:0] x_psrc0,
    output logic [TAG_W-1:0] x_psrc1,
    output logic [TAG_W-1:0] x_pdst,
    output logic [TAG_W-1:0] x_pold,
    output logic [TAG_W-1:0] y_psrc0,
    output logic [TAG_W-1:0] y_psrc1,
    output logic [TAG_W-1:0] y_pdst,
    output logic [TAG_W-1:0] y_pold,
    output logic             stall
);

    slot_req_t x_req;
    slot_req_t y_req;
    slot_rsp_t x_rsp;
    slot_rsp_t y_rsp;
    map_vec_t  map_q;
    ptag_t     x_tag;
    ptag_t     y_tag;
    logic      need_x;
    logic      need_y;
    logic      commit_x;
    logic      commit_y;

    assign x_req = '{valid: x_valid, src0: x_src0, src1: x_src1, dst_en: x_dst_en, dst: x_dst};
    assign y_req = '{valid: y_valid, src0: y_src0, src1: y_src1, dst_en: y_dst_en, dst: y_dst};

    rn_free_list u_pool (
        .clk      (clk),
        .rst      (rst),
        .need_x   (need_x),
        .need_y   (need_y),
        .rel0_en  (rel0_en),
        .rel0_tag (rel0_tag),
        .rel1_en  (rel1_en),
        .rel1_tag (rel1_tag),
        .x_tag    (x_tag),
        .y_tag    (y_tag),
        .stall    (stall)
    );

    rn_pair_resolve u_resolve (
        .x_req    (x_req),
        .y_req    (y_req),
        .map_q    (map_q),
        .x_tag    (x_tag),
        .y_tag    (y_tag),
        .stall    (stall),
        .need_x   (need_x),
        .need_y   (need_y),
        .commit_x (commit_x),
        .commit_y (commit_y),
        .x_rsp    (x_rsp),
        .y_rsp    (y_rsp)
    );

    rn_map_table u_map (
        .clk      (clk),
        .rst      (rst),
        .wr_x_en  (commit_x),
        .wr_x_reg (x_dst),
        .wr_x_tag (x_tag),
        .wr_y_en  (commit_y),
        .wr_y_reg (y_dst),
        .wr_y_tag (y_tag),
        .map_q    (map_q)
    );

    assign x_psrc0 = x_rsp.psrc0;
    assign x_psrc1 = x_rsp.psrc1;
    assign x_pdst  = x_rsp.pdst;
    assign x_pold  = x_rsp.pold;
    assign y_psrc0 = y_rsp.psrc0;
    assign y_psrc1 = y_rsp.psrc1;
    assign y_pdst  = y_rsp.pdst;
    assign y_pold  = y_rsp.pold;

    // R4: a new tag is never one the table still points at
    a_r4_fresh_x: assert property (@(posedge clk) disable iff (rst)
        commit_x |-> !tag_in_map(map_q, x_tag));
    a_r4_fresh_y: assert property (@(posedge clk) disable iff (rst)
        commit_y |-> !tag_in_map(map_q, y_tag));
    // R4: both slots of one pair receive different tags
    a_r4_distinct_pair: assert property (@(posedge clk) disable iff (rst)
        (commit_x && commit_y) |-> (x_tag != y_tag));
    // R9: a stalled cycle leaves the table untouched
    a_r9_stall_freezes: assert property (@(posedge clk) disable iff (rst)
        stall |=> (map_q == $past(map_q)));

endmodule

// File: tb/tb_rename_pair.sv
module tb_rename_pair;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic       x_valid, x_dst_en, y_valid, y_dst_en, rel0_en, rel1_en;
    logic [2:0] x_src0, x_src1, x_dst, y_src0, y_src1, y_dst;
    logic [4:0] rel0_tag, rel1_tag;
    logic [4:0] x_psrc0, x_psrc1, x_pdst, x_pold, y_psrc0, y_psrc1, y_pdst, y_pold;
    logic       stall;

    rename_pair dut (.*);

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct packed {
        logic xv; logic [2:0] xs0; logic [2:0] xs1; logic xde; logic [2:0] xd;
        logic yv; logic [2:0] ys0; logic [2:0] ys1; logic yde; logic [2:0] yd;
        logic r0e; logic [4:0] r0t; logic r1e; logic [4:0] r1t;
        logic [4:0] e_xs0; logic [4:0] e_xs1; logic [4:0] e_xpd; logic [4:0] e_xpo;
        logic [4:0] e_ys0; logic [4:0] e_ys1; logic [4:0] e_ypd; logic [4:0] e_ypo;
        logic e_stall;
    } vec_t;

    // walked straight after reset; each row's expectations follow the previous rows
    localparam vec_t VECS [4] = '{
        // R2 R4: X reads AX(0) while Y rewrites AX; X gets 8, Y gets 9
        '{1'b1,3'd0,3'd2,1'b1,3'd1, 1'b1,3'd0,3'd2,1'b1,3'd0, 1'b0,5'd0,1'b0,5'd0,
          5'd0,5'd2,5'd8,5'd1, 5'd0,5'd2,5'd9,5'd0, 1'b0},
        // R3 R5 R6: both write reg 0; Y src0 forwarded 10, Y old = 10
        '{1'b1,3'd3,3'd3,1'b1,3'd0, 1'b1,3'd0,3'd1,1'b1,3'd0, 1'b0,5'd0,1'b0,5'd0,
          5'd3,5'd3,5'd10,5'd9, 5'd10,5'd8,5'd11,5'd10, 1'b0},
        // R7 R4: X invalid, Y takes lowest 12, no forward of reg 5; R8 release 1 and 0
        '{1'b0,3'd5,3'd5,1'b1,3'd5, 1'b1,3'd0,3'd5,1'b1,3'd5, 1'b1,5'd1,1'b1,5'd0,
          5'd5,5'd5,5'd0,5'd5, 5'd11,5'd5,5'd12,5'd5, 1'b0},
        // R8: released tag 0 reused by X; R3 Y reads reg 2 forwarded; R7 Y no dst
        '{1'b1,3'd1,3'd5,1'b1,3'd2, 1'b1,3'd2,3'd2,1'b0,3'd3, 1'b0,5'd0,1'b0,5'd0,
          5'd8,5'd12,5'd0,5'd2, 5'd0,5'd0,5'd0,5'd3, 1'b0}
    };

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive(logic xv, logic [2:0] xs0, logic [2:0] xs1, logic xde, logic [2:0] xd,
                         logic yv, logic [2:0] ys0, logic [2:0] ys1, logic yde, logic [2:0] yd,
                         logic r0e, logic [4:0] r0t, logic r1e, logic [4:0] r1t);
        @(negedge clk);
        x_valid = xv; x_src0 = xs0; x_src1 = xs1; x_dst_en = xde; x_dst = xd;
        y_valid = yv; y_src0 = ys0; y_src1 = ys1; y_dst_en = yde; y_dst = yd;
        rel0_en = r0e; rel0_tag = r0t; rel1_en = r1e; rel1_tag = r1t;
        #2;
    endtask

    task automatic idle();
        drive(0,0,0,0,0, 0,0,0,0,0, 0,0,0,0);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog run did not finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset state seen through a read-only pair
        drive(1,7,6,0,0, 1,5,4,0,0, 0,0,0,0);
        check("R1", "x_psrc0", x_psrc0, 7);
        check("R1", "y_psrc1", y_psrc1, 4);
        check("R1", "stall", stall, 0);
        check("R7", "x_pdst none", x_pdst, 0);

        foreach (VECS[i]) begin
            drive(VECS[i].xv, VECS[i].xs0, VECS[i].xs1, VECS[i].xde, VECS[i].xd,
                  VECS[i].yv, VECS[i].ys0, VECS[i].ys1, VECS[i].yde, VECS[i].yd,
                  VECS[i].r0e, VECS[i].r0t, VECS[i].r1e, VECS[i].r1t);
            check("R2", $sformatf("v%0d x_psrc0", i), x_psrc0, VECS[i].e_xs0);
            check("R2", $sformatf("v%0d x_psrc1", i), x_psrc1, VECS[i].e_xs1);
            check("R4", $sformatf("v%0d x_pdst", i),  x_pdst,  VECS[i].e_xpd);
            check("R5", $sformatf("v%0d x_pold", i),  x_pold,  VECS[i].e_xpo);
            check("R3", $sformatf("v%0d y_psrc0", i), y_psrc0, VECS[i].e_ys0);
            check("R3", $sformatf("v%0d y_psrc1", i), y_psrc1, VECS[i].e_ys1);
            check("R4", $sformatf("v%0d y_pdst", i),  y_pdst,  VECS[i].e_ypd);
            check("R5", $sformatf("v%0d y_pold", i),  y_pold,  VECS[i].e_ypo);
            check("R9", $sformatf("v%0d stall", i),   stall,   VECS[i].e_stall);
        end

        // R6: reg 0 ended at Y's tag 11 from the shared-write row, reg 2 at 0
        drive(1,0,2,0,0, 0,0,0,0,0, 0,0,0,0);
        check("R6", "reg0 final", x_psrc0, 11);
        check("R6", "reg2 final", x_psrc1, 0);

        // drain the pool (1, 13..31 left): ten pairs both writing reg 7
        for (int k = 0; k < 10; k++) begin
            int ex_x, ex_y, prev;
            ex_x = (k == 0) ? 1  : 12 + 2 * k;
            ex_y = (k == 0) ? 13 : 13 + 2 * k;
            prev = (k == 0) ? 7  : 13 + 2 * (k - 1);
            drive(1,7,6,1,7, 1,7,0,1,7, 0,0,0,0);
            check("R4", $sformatf("drain%0d x_pdst", k), x_pdst, ex_x);
            check("R4", $sformatf("drain%0d y_pdst", k), y_pdst, ex_y);
            check("R2", $sformatf("drain%0d x_psrc0", k), x_psrc0, prev);
            check("R3", $sformatf("drain%0d y_psrc0", k), y_psrc0, ex_x);
            check("R5", $sformatf("drain%0d y_pold", k), y_pold, ex_x);
        end

        // R9: pool empty, single write stalls; release of 20 still applies
        drive(1,7,0,1,6, 0,0,0,0,0, 1,20,0,0);
        check("R9", "empty stall", stall, 1);
        check("R9", "stalled x_pdst", x_pdst, 0);
        check("R9", "stalled src", x_psrc0, 31);

        // R9: one free tag, pair needs two
        drive(1,7,6,1,6, 1,6,0,1,5, 0,0,0,0);
        check("R9", "short stall", stall, 1);
        check("R9", "short y_pdst", y_pdst, 0);
        check("R9", "y src no forward", y_psrc0, 6);

        // R8: released tag 20 now allocated
        drive(1,7,6,1,6, 0,0,0,0,0, 0,0,0,0);
        check("R8", "reuse stall", stall, 0);
        check("R8", "reuse x_pdst", x_pdst, 20);
        check("R5", "reuse x_pold", x_pold, 6);

        drive(1,6,5,0,0, 0,0,0,0,0, 0,0,0,0);
        check("R9", "reg6 after", x_psrc0, 20);
        check("R9", "reg5 untouched by stall", x_psrc1, 12);

        // R1: mid-run reset restores identity and the pool
        idle();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        drive(1,7,6,1,7, 1,7,0,1,1, 0,0,0,0);
        check("R1", "reset x_psrc0", x_psrc0, 7);
        check("R1", "reset x_psrc1", x_psrc1, 6);
        check("R1", "reset x_pdst", x_pdst, 8);
        check("R1", "reset y_pdst", y_pdst, 9);
        check("R3", "reset y_psrc0", y_psrc0, 8);
        check("R2", "reset y_psrc1", y_psrc1, 0);

        idle();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule